// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor in which every instruction is fetched, decoded, executed and retired within one clock period. It runs a compact subset of seven instructions: register add and subtract, OR with an immediate, word load, word store, branch-if-equal and an absolute jump. The PC and the register file change only on the rising clock edge. Register reads, immediate extension, ALU work and data-memory reads all settle between edges.

Program and data live in two small internal word-addressed memories. A test environment fills them through a load port while the core is held in reset. Every store the core performs is reported one cycle later on a registered store-report port. The current PC is also visible, so results can be checked without looking into the core.

Instruction formats: opcode in bits [31:26], first source register in [25:21], second source or load/immediate target in [20:16], R-type destination in [15:11], R-type function code in [5:0], and a 16-bit immediate in [15:0]. Register 0 is hard-wired to zero.

Top module: `sc_cpu_core`

## Requirements
- R1: While `rst` is high, `pc_o` reads 0 and `st_valid_o` reads 0. The first instruction after reset comes from word 0 of instruction memory.
- R2: Opcode 000000 with function 100001 writes rs+rt to rd, and with function 100011 writes rs-rt to rd. Both wrap modulo 2^32.
- R3: Opcode 001101 writes rs OR the zero-extended 16-bit immediate to rt, so immediate bit 15 never reaches the upper half.
- R4: Opcode 100011 loads the data word at byte address rs+sign_ext(imm) into rt. A negative offset reaches lower addresses, and a word stored in an earlier cycle is read back.
- R5: Opcode 101011 writes rt to the data word at byte address rs+sign_ext(imm) on the clock edge. On the next cycle `st_valid_o` is 1 and `st_addr_o`/`st_data_o` carry that address and data. In every other cycle `st_valid_o` is 0.
- R6: Opcode 000100 compares rs and rt. If they are equal, the next PC is PC+4+(sign_ext(imm)<<2), and backward offsets are allowed. If they differ, the next PC is PC+4.
- R7: Opcode 000010 sets the next PC to {(PC+4)[31:28], instr[25:0], 00}.
- R8: Register 0 always reads as zero. Writes that name it as destination have no effect.
- R9: Any other opcode writes no register and no memory, and only advances the PC by 4.
- R10: Every instruction that does not change the flow of control advances the PC by exactly 4 in one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | Load-port target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Load-port word address |
| ld_data | input | 32 | Load-port write data |
| pc_o | output | 32 | Current program counter (byte address) |
| st_valid_o | output | 1 | A store retired in the previous cycle |
| st_addr_o | output | 32 | Byte address of that store |
| st_data_o | output | 32 | Data written by that store |

## Verification
One program runs through every corner of the subset, and each of its results leaves the core as a store. An OR-immediate with bit 15 set would show a sign-extended upper half if the extender were wrong. A load through a negative offset from a word stored earlier would hit the wrong word, or return stale data, if the sign extension or the store-then-load path were broken. Writes to register 0 followed by a store of register 0 would expose a register that is not hard-wired. A taken and an untaken branch, a jump, and an unsupported opcode each sit in front of stores that must or must not appear, so a wrong target or a side effect from the no-op would show up as an unexpected, missing or corrupted store. The final self-loop branch checks backward offsets through the PC at which the program settles.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN  = 32;
  localparam int NREG  = 32;
  localparam int RAW   = $clog2(NREG);

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;

  localparam logic [5:0] FN_ADDU  = 6'b100001;
  localparam logic [5:0] FN_SUBU  = 6'b100011;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_OR    = 2'b11
  } aluop_e;

  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_OR  = 2'd2
  } alufn_e;

  typedef struct packed {
    logic   reg_dst;
    logic   alu_src;
    logic   mem_to_reg;
    logic   reg_write;
    logic   mem_read;
    logic   mem_write;
    logic   branch;
    logic   jump;
    logic   zero_ext;
    aluop_e aluop;
  } ctrl_t;
endpackage

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl,
  output alufn_e     alu_fn
);
  always_comb begin
    ctrl = '0;
    ctrl.aluop = AOP_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.reg_dst   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.aluop     = AOP_FUNCT;
      end
      OP_LW: begin
        ctrl.alu_src    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
        ctrl.reg_write  = 1'b1;
        ctrl.mem_read   = 1'b1;
      end
      OP_SW: begin
        ctrl.alu_src   = 1'b1;
        ctrl.mem_write = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluop  = AOP_SUB;
      end
      OP_ORI: begin
        ctrl.alu_src   = 1'b1;
        ctrl.reg_write = 1'b1;
        ctrl.zero_ext  = 1'b1;
        ctrl.aluop     = AOP_OR;
      end
      OP_JMP: ctrl.jump = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    unique case (ctrl.aluop)
      AOP_SUB:   alu_fn = FN_SUB;
      AOP_OR:    alu_fn = FN_OR;
      AOP_FUNCT: alu_fn = (funct == FN_SUBU) ? FN_SUB : FN_ADD;
      default:   alu_fn = FN_ADD;
    endcase
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alufn_e       fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      FN_SUB:  y = a - b;
      FN_OR:   y = a | b;
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_cpu_core.sv
module sc_cpu_core
  import sc_pkg::*;
#(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_we,
  input  logic             ld_dmem,
  input  logic [LD_AW-1:0] ld_addr,
  input  logic [XLEN-1:0]  ld_data,
  output logic [XLEN-1:0]  pc_o,
  output logic             st_valid_o,
  output logic [XLEN-1:0]  st_addr_o,
  output logic [XLEN-1:0]  st_data_o
);
  localparam int IWORDS = 1 << IMEM_AW;
  localparam int DWORDS = 1 << DMEM_AW;

  logic [XLEN-1:0] imem [IWORDS];
  logic [XLEN-1:0] dmem [DWORDS];

  logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, jmp_tgt, pc_next;
  logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y;
  logic [XLEN-1:0] dm_rd, wb_data;
  logic [RAW-1:0]  wr_idx;
  logic            alu_zero;
  ctrl_t           ctrl;
  alufn_e          alu_fn;

  // fetch
  assign instr = imem[pc_q[IMEM_AW+1:2]];

  always_ff @(posedge clk) begin
    if (ld_we && !ld_dmem) imem[ld_addr[IMEM_AW-1:0]] <= ld_data;
  end

  // decode
  sc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl),
    .alu_fn (alu_fn)
  );

  assign imm_ext = ctrl.zero_ext ? {16'h0, instr[15:0]}
                                 : {{16{instr[15]}}, instr[15:0]};
  assign wr_idx  = ctrl.reg_dst ? instr[15:11] : instr[20:16];

  sc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (ctrl.reg_write && !rst),
    .wa  (wr_idx),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rs_val),
    .rd2 (rt_val)
  );

  // execute
  assign alu_b = ctrl.alu_src ? imm_ext : rt_val;

  sc_alu #(.W(XLEN)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .fn   (alu_fn),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: loader has priority, core writes only out of reset
  logic                dm_we;
  logic [DMEM_AW-1:0]  dm_wa;
  logic [XLEN-1:0]     dm_wd;

  assign dm_we = (ld_we && ld_dmem) || (ctrl.mem_write && !rst);
  assign dm_wa = (ld_we && ld_dmem) ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
  assign dm_wd = (ld_we && ld_dmem) ? ld_data : rt_val;

  always_ff @(posedge clk) begin
    if (dm_we) dmem[dm_wa] <= dm_wd;
  end

  assign dm_rd   = ctrl.mem_read ? dmem[alu_y[DMEM_AW+1:2]] : '0;
  assign wb_data = ctrl.mem_to_reg ? dm_rd : alu_y;

  // next PC
  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                     pc_next = jmp_tgt;
    else if (ctrl.branch && alu_zero)  pc_next = br_tgt;
    else                               pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      st_valid_o <= 1'b0;
      st_addr_o  <= '0;
      st_data_o  <= '0;
    end else begin
      pc_q       <= pc_next;
      st_valid_o <= ctrl.mem_write;
      st_addr_o  <= alu_y;
      st_data_o  <= rt_val;
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/sc_cpu_chk.sv
module sc_cpu_chk
  import sc_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] instr,
  input logic            st_valid,
  input logic [RAW-1:0]  rs_idx,
  input logic [XLEN-1:0] rs_val
);
  AST_RESET_PC: assert property (@(posedge clk) rst |=> (pc == '0 && !st_valid)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != OP_BEQ && instr[31:26] != OP_JMP) |=> (pc == $past(pc) + 32'd4)); // R10

  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_JMP) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00})); // R7

  AST_STORE_SEEN: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == OP_SW) |=> st_valid); // R5

  AST_NO_STRAY_STORE: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] != OP_SW) |=> !st_valid); // R5

  AST_R0_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rs_idx == '0) |-> (rs_val == '0)); // R8
endmodule

bind sc_cpu_core sc_cpu_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pc       (pc_q),
  .instr    (instr),
  .st_valid (st_valid_o),
  .rs_idx   (instr[25:21]),
  .rs_val   (rs_val)
);

// File: tb/sc_cpu_core_tb.sv
module sc_cpu_core_tb;
  localparam int LD_AW = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_dmem = 1'b0;
  logic [LD_AW-1:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o, st_addr_o, st_data_o;
  logic        st_valid_o;

  int tests = 0;
  int fails = 0;
  int stores_seen = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  sc_cpu_core u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_dmem(ld_dmem),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_o(pc_o),
    .st_valid_o(st_valid_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                        logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                        logic [4:0] rd, logic [5:0] fn);
    return {6'b000000, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(bit to_dmem, int addr, logic [31:0] data);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = to_dmem;
    ld_addr = addr[LD_AW-1:0]; ld_data = data;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic expect_store(logic [31:0] a, logic [31:0] d, string req);
    exp_t e;
    e.addr = a; e.data = d; e.req = req;
    sb.push_back(e);
  endtask

  // monitor: compare each reported store against the scoreboard
  always @(negedge clk) begin
    if (!rst && st_valid_o) begin
      stores_seen++;
      if (sb.size() == 0) begin
        tests++; fails++;
        $display("FAIL R6/R7 skipped path stored: actual %h=%h expected none",
                 st_addr_o, st_data_o);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.req, " addr"}, st_addr_o, e.addr);
        check({e.req, " data"}, st_data_o, e.data);
      end
    end
  end

  initial begin
    logic [31:0] prog [24];
    prog[0]  = enc_i(6'b001101, 5'd0, 5'd1, 16'h8005);     // ORI r1
    prog[1]  = enc_i(6'b101011, 5'd0, 5'd1, 16'd0);        // SW r1,0
    prog[2]  = enc_i(6'b100011, 5'd0, 5'd2, 16'd4);        // LW r2,4
    prog[3]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100001);         // ADDU r3
    prog[4]  = enc_i(6'b101011, 5'd0, 5'd3, 16'd8);        // SW r3,8
    prog[5]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100011);         // SUBU r4
    prog[6]  = enc_i(6'b101011, 5'd0, 5'd4, 16'd12);       // SW r4,12
    prog[7]  = enc_i(6'b001101, 5'd0, 5'd5, 16'h0010);     // ORI r5=16
    prog[8]  = enc_i(6'b100011, 5'd5, 5'd6, 16'hFFFC);     // LW r6,-4(r5)
    prog[9]  = enc_i(6'b101011, 5'd0, 5'd6, 16'd16);       // SW r6,16
    prog[10] = enc_i(6'b001101, 5'd0, 5'd0, 16'h7777);     // ORI r0
    prog[11] = enc_r(5'd1, 5'd1, 5'd0, 6'b100001);         // ADDU r0
    prog[12] = enc_i(6'b101011, 5'd0, 5'd0, 16'd20);       // SW r0,20
    prog[13] = enc_i(6'b000100, 5'd1, 5'd2, 16'd5);        // BEQ not taken
    prog[14] = enc_i(6'b101011, 5'd0, 5'd1, 16'd24);       // SW r1,24
    prog[15] = enc_i(6'b000100, 5'd1, 5'd1, 16'd2);        // BEQ taken -> 18
    prog[16] = enc_i(6'b101011, 5'd0, 5'd2, 16'd28);       // skipped
    prog[17] = enc_i(6'b101011, 5'd0, 5'd2, 16'd28);       // skipped
    prog[18] = enc_i(6'b111111, 5'd1, 5'd1, 16'hFFFF);     // unsupported
    prog[19] = enc_i(6'b101011, 5'd0, 5'd1, 16'd32);       // SW r1,32
    prog[20] = {6'b000010, 26'd23};                        // J 23
    prog[21] = enc_i(6'b101011, 5'd0, 5'd2, 16'd36);       // skipped
    prog[22] = enc_i(6'b101011, 5'd0, 5'd2, 16'd36);       // skipped
    prog[23] = enc_i(6'b000100, 5'd0, 5'd0, 16'hFFFF);     // self loop

    for (int i = 0; i < 24; i++) load(1'b0, i, prog[i]);
    load(1'b1, 1, 32'h1234_5678);

    expect_store(32'd0,  32'h0000_8005, "R3");
    expect_store(32'd8,  32'h1234_D67D, "R2 add");
    expect_store(32'd12, 32'hEDCC_298D, "R2 sub");
    expect_store(32'd16, 32'hEDCC_298D, "R4");
    expect_store(32'd20, 32'h0000_0000, "R8");
    expect_store(32'd24, 32'h0000_8005, "R6 not taken");
    expect_store(32'd32, 32'h0000_8005, "R9");

    @(negedge clk);
    check("R1 pc", pc_o, 32'h0);
    check("R1 st_valid", {31'd0, st_valid_o}, 32'h0);

    rst = 1'b0;
    @(posedge clk); #1;
    check("R10 first step", pc_o, 32'h4);

    repeat (60) @(posedge clk);
    #1;
    check("R6 backward loop pc", pc_o, 32'h5C);
    check("R5 pending stores", sb.size(), 32'd0);
    check("R5 store count", stores_seen, 32'd7);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule